// File: doc/BRIEF.md
# Memory Dependency Group Tracker

This block keeps a table of memory groups for an out-of-order scheduler. A group collects memory operations that share identical dependencies, so it is scheduled as a unit. For each group the table counts its predecessor groups, how many of those predecessors have started issuing, and how many have finished. It also counts how many instructions belong to the group, how many are in flight, and how many have completed. From these counters each group shows one readiness flag of waiting, pending or ready, and one progress flag of executing or executed.

One command is accepted per cycle. A command can add an instruction to a group, link a successor group, report that an instruction issued, or report that one completed. Successor links come in two kinds. An order link is released as soon as the predecessor group has every remaining instruction in flight. A data link turns into an in-flight predecessor at that point, and is released only when the predecessor has completed every instruction. A per-cycle tick counts down each waiting group's estimate of how many cycles its slowest data predecessor still needs.

That estimate is the largest cycles-left value among all instructions issued into a data predecessor. A command that breaks a precondition is dropped and raises a sticky error flag.

Top module: `mdg_tracker`

## Requirements
- R1: After reset every counter is zero. Every group reads ready and executed, and none reads waiting, pending or executing. The error flag and every critical-cycle value are zero.
- R2: For each group, the three readiness flags compare the predecessor total with the in-flight and done predecessor counts:
  - waiting is set while the total exceeds the sum of in-flight and done;
  - pending is set while in-flight is nonzero and that sum equals the total;
  - ready is set while done equals the total.
- R3: A group is executing while its in-flight instruction count is nonzero and equals its instruction count minus its completed count. It is executed while the completed count equals the instruction count.
- R4: An issue that makes a group executing moves each of its order successors straight to one more done predecessor. The same issue gives each of its data successors one more in-flight predecessor.
- R5: A completion that makes a group executed moves one predecessor of each data successor from in-flight to done. Earlier completions in that group leave its data successors unchanged.
- R6: A successor link works as follows:
  - it raises the successor's predecessor total and records the link in the target's order or data list;
  - an order link to a target that is already executing changes nothing;
  - a data link to an executing target also counts at once as an in-flight predecessor and raises the successor's critical value to the target's.
- R7: Critical-cycle value (read through `crit_sel_i`/`crit_cycles_o`):
  - a tick lowers it by one when the group is waiting and the value is nonzero;
  - a data predecessor that starts executing raises it to that predecessor's largest issued cycles-left value;
  - when a tick and a raise fall in the same cycle, the decrement applies first and then the maximum is taken;
  - ticks never change any flag.
- R8: A command is rejected, and changes no counter, when any of the following holds:
  - it adds an instruction to a group that has a successor, or whose instruction count is at its maximum;
  - it links a group to itself, links a group that is executed, or repeats an existing link;
  - it issues when in-flight plus completed already equals the instruction count;
  - it reports a completion for a group that is not ready or has nothing in flight.
  A rejection sets `err_o`, which stays set until reset.
- R9: Commands act only while `cmd_valid_i` is high. The `cmd_op_i` encoding is 0 add instruction, 1 add successor, 2 issue, 3 complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code (R9) |
| cmd_grp_i | input | 4 | Target group index |
| cmd_succ_i | input | 4 | Successor group index for a link |
| cmd_data_i | input | 1 | Link kind: 1 data, 0 order |
| cmd_cycles_i | input | 8 | Cycles left of an issued instruction |
| tick_i | input | 1 | Per-cycle countdown strobe |
| crit_sel_i | input | 4 | Group whose critical value is shown |
| crit_cycles_o | output | 8 | Critical-cycle value of the selected group |
| waiting_o | output | 16 | Per-group waiting flag |
| pending_o | output | 16 | Per-group pending flag |
| ready_o | output | 16 | Per-group ready flag |
| executing_o | output | 16 | Per-group executing flag |
| executed_o | output | 16 | Per-group executed flag |
| err_o | output | 1 | Sticky command error |

## Verification
The tick countdown and the raise from a data predecessor can both hit the same group in the same cycle. A directed step provokes this:
- the bench makes a group waiting with a nonzero critical value;
- it then issues the last instruction of one of that group's data predecessors while ticking, using a cycles-left value below the current value minus one;
- the result is judged against the decremented value, not the incoming one.

Random traffic with ticks held high about half the time revisits this overlap against a bench model that applies the decrement before the maximum.

// File: rtl/mdg_pkg.sv
package mdg_pkg;

    typedef enum logic [1:0] {
        OP_ADD_INST = 2'd0,
        OP_ADD_SUCC = 2'd1,
        OP_ISSUE    = 2'd2,
        OP_EXEC     = 2'd3
    } mdg_op_e;

    typedef struct packed {
        logic waiting;
        logic pending;
        logic ready;
        logic executing;
        logic executed;
    } grp_flags_t;

endpackage

// File: rtl/mdg_flags.sv
// Derives the readiness and progress flags of one group from its counters.
module mdg_flags #(
    parameter int PRED_W = 5,
    parameter int INST_W = 4
) (
    input  logic [PRED_W-1:0]      npred_i,
    input  logic [PRED_W-1:0]      nexing_i,
    input  logic [PRED_W-1:0]      nexdone_i,
    input  logic [INST_W-1:0]      ninst_i,
    input  logic [INST_W-1:0]      nfly_i,
    input  logic [INST_W-1:0]      ndone_i,
    output mdg_pkg::grp_flags_t    flags_o
);

    logic [PRED_W:0]   settled;
    logic [PRED_W:0]   total;
    logic [INST_W-1:0] remaining;

    assign settled   = {1'b0, nexing_i} + {1'b0, nexdone_i};
    assign total     = {1'b0, npred_i};
    assign remaining = ninst_i - ndone_i;

    always_comb begin
        flags_o.waiting   = total > settled;
        flags_o.pending   = (nexing_i != '0) && (settled == total);
        flags_o.ready     = (nexdone_i == npred_i);
        flags_o.executing = (nfly_i != '0) && (nfly_i == remaining);
        flags_o.executed  = (ninst_i == ndone_i);
    end

endmodule

// File: rtl/mdg_cmd_check.sv
// Decides whether the command presented this cycle may be applied.
module mdg_cmd_check #(
    parameter int NUM_GROUPS = 16,
    parameter int IDX_W      = 4,
    parameter int INST_W     = 4
) (
    input  logic                  valid_i,
    input  mdg_pkg::mdg_op_e      op_i,
    input  logic [IDX_W-1:0]      grp_i,
    input  logic [IDX_W-1:0]      succ_i,
    input  logic                  tgt_ready_i,
    input  logic                  tgt_executed_i,
    input  logic [INST_W-1:0]     tgt_ninst_i,
    input  logic [INST_W-1:0]     tgt_nfly_i,
    input  logic [INST_W-1:0]     tgt_ndone_i,
    input  logic [NUM_GROUPS-1:0] tgt_links_i,
    output logic                  accept_o,
    output logic                  reject_o
);

    localparam logic [IDX_W:0]  GRP_LIMIT = (IDX_W+1)'(NUM_GROUPS);
    localparam logic [INST_W-1:0] INST_MAX = '1;

    logic grp_in;
    logic succ_in;
    logic linked;
    logic legal;

    assign grp_in  = {1'b0, grp_i}  < GRP_LIMIT;
    assign succ_in = {1'b0, succ_i} < GRP_LIMIT;
    assign linked  = succ_in ? tgt_links_i[succ_i] : 1'b0;

    always_comb begin
        legal = 1'b0;
        unique case (op_i)
            mdg_pkg::OP_ADD_INST: legal = (tgt_links_i == '0) && (tgt_ninst_i != INST_MAX);
            mdg_pkg::OP_ADD_SUCC: legal = succ_in && (succ_i != grp_i) && !tgt_executed_i && !linked;
            mdg_pkg::OP_ISSUE:    legal = ({1'b0, tgt_nfly_i} + {1'b0, tgt_ndone_i}) < {1'b0, tgt_ninst_i};
            mdg_pkg::OP_EXEC:     legal = tgt_ready_i && (tgt_nfly_i != '0);
            default:              legal = 1'b0;
        endcase
    end

    assign accept_o = valid_i && grp_in && legal;
    assign reject_o = valid_i && !(grp_in && legal);

endmodule

// File: rtl/mdg_tracker.sv
// Table of memory dependency groups with successor notification.
module mdg_tracker #(
    parameter int NUM_GROUPS = 16,
    parameter int INST_W     = 4,
    parameter int CYC_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid_i,
    input  logic [1:0]            cmd_op_i,
    input  logic [$clog2(NUM_GROUPS)-1:0] cmd_grp_i,
    input  logic [$clog2(NUM_GROUPS)-1:0] cmd_succ_i,
    input  logic                  cmd_data_i,
    input  logic [CYC_W-1:0]      cmd_cycles_i,
    input  logic                  tick_i,
    input  logic [$clog2(NUM_GROUPS)-1:0] crit_sel_i,
    output logic [CYC_W-1:0]      crit_cycles_o,
    output logic [NUM_GROUPS-1:0] waiting_o,
    output logic [NUM_GROUPS-1:0] pending_o,
    output logic [NUM_GROUPS-1:0] ready_o,
    output logic [NUM_GROUPS-1:0] executing_o,
    output logic [NUM_GROUPS-1:0] executed_o,
    output logic                  err_o
);

    localparam int IDX_W  = $clog2(NUM_GROUPS);
    localparam int PRED_W = $clog2(NUM_GROUPS + 1);
    localparam logic [IDX_W:0] GRP_LIMIT = (IDX_W+1)'(NUM_GROUPS);

    typedef struct packed {
        logic [PRED_W-1:0]     npred;
        logic [PRED_W-1:0]     nexing;
        logic [PRED_W-1:0]     nexdone;
        logic [INST_W-1:0]     ninst;
        logic [INST_W-1:0]     nfly;
        logic [INST_W-1:0]     ndone;
        logic [CYC_W-1:0]      crit;
        logic [CYC_W-1:0]      icrit;
        logic [NUM_GROUPS-1:0] osucc;
        logic [NUM_GROUPS-1:0] dsucc;
    } grp_t;

    typedef struct packed {
        grp_t [NUM_GROUPS-1:0] g;
        logic                  err;
    } state_t;

    state_t q, d;

    mdg_pkg::grp_flags_t flags [NUM_GROUPS];
    mdg_pkg::mdg_op_e    op;
    logic [IDX_W-1:0]    grp_idx;
    logic [IDX_W-1:0]    succ_idx;
    logic [IDX_W-1:0]    sel_idx;
    grp_t                tgt;
    mdg_pkg::grp_flags_t tgt_flags;
    logic                accept;
    logic                reject;
    logic                issue_starts;
    logic                exec_finishes;
    logic [CYC_W-1:0]    icrit_next;

    function automatic logic [CYC_W-1:0] f_max(input logic [CYC_W-1:0] a, input logic [CYC_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    assign op       = mdg_pkg::mdg_op_e'(cmd_op_i);
    assign grp_idx  = ({1'b0, cmd_grp_i}  < GRP_LIMIT) ? cmd_grp_i  : '0;
    assign succ_idx = ({1'b0, cmd_succ_i} < GRP_LIMIT) ? cmd_succ_i : '0;
    assign sel_idx  = ({1'b0, crit_sel_i} < GRP_LIMIT) ? crit_sel_i : '0;
    assign tgt       = q.g[grp_idx];
    assign tgt_flags = flags[grp_idx];

    // Issue completes the in-flight set; completion finishes the group.
    assign issue_starts  = ({1'b0, tgt.nfly} + {1'b0, tgt.ndone} + (INST_W+1)'(1)) == {1'b0, tgt.ninst};
    assign exec_finishes = ({1'b0, tgt.ndone} + (INST_W+1)'(1)) == {1'b0, tgt.ninst};
    assign icrit_next    = f_max(tgt.icrit, cmd_cycles_i);

    generate
        for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_grp
            mdg_flags #(
                .PRED_W (PRED_W),
                .INST_W (INST_W)
            ) u_flags (
                .npred_i   (q.g[gi].npred),
                .nexing_i  (q.g[gi].nexing),
                .nexdone_i (q.g[gi].nexdone),
                .ninst_i   (q.g[gi].ninst),
                .nfly_i    (q.g[gi].nfly),
                .ndone_i   (q.g[gi].ndone),
                .flags_o   (flags[gi])
            );
            assign waiting_o[gi]   = flags[gi].waiting;
            assign pending_o[gi]   = flags[gi].pending;
            assign ready_o[gi]     = flags[gi].ready;
            assign executing_o[gi] = flags[gi].executing;
            assign executed_o[gi]  = flags[gi].executed;
        end
    endgenerate

    mdg_cmd_check #(
        .NUM_GROUPS (NUM_GROUPS),
        .IDX_W      (IDX_W),
        .INST_W     (INST_W)
    ) u_check (
        .valid_i        (cmd_valid_i),
        .op_i           (op),
        .grp_i          (cmd_grp_i),
        .succ_i         (cmd_succ_i),
        .tgt_ready_i    (tgt_flags.ready),
        .tgt_executed_i (tgt_flags.executed),
        .tgt_ninst_i    (tgt.ninst),
        .tgt_nfly_i     (tgt.nfly),
        .tgt_ndone_i    (tgt.ndone),
        .tgt_links_i    (tgt.osucc | tgt.dsucc),
        .accept_o       (accept),
        .reject_o       (reject)
    );

    always_comb begin
        d = q;

        // Countdown of the critical estimate for waiting groups.
        for (int i = 0; i < NUM_GROUPS; i++) begin
            if (tick_i && flags[i].waiting && (q.g[i].crit != '0)) begin
                d.g[i].crit = q.g[i].crit - CYC_W'(1);
            end
        end

        if (reject) begin
            d.err = 1'b1;
        end else if (accept) begin
            unique case (op)
                mdg_pkg::OP_ADD_INST: begin
                    d.g[grp_idx].ninst = tgt.ninst + INST_W'(1);
                end
                mdg_pkg::OP_ADD_SUCC: begin
                    if (cmd_data_i || !tgt_flags.executing) begin
                        d.g[succ_idx].npred = q.g[succ_idx].npred + PRED_W'(1);
                        if (tgt_flags.executing) begin
                            d.g[succ_idx].nexing = q.g[succ_idx].nexing + PRED_W'(1);
                            d.g[succ_idx].crit   = f_max(d.g[succ_idx].crit, tgt.icrit);
                        end
                        if (cmd_data_i) begin
                            d.g[grp_idx].dsucc[succ_idx] = 1'b1;
                        end else begin
                            d.g[grp_idx].osucc[succ_idx] = 1'b1;
                        end
                    end
                end
                mdg_pkg::OP_ISSUE: begin
                    d.g[grp_idx].nfly  = tgt.nfly + INST_W'(1);
                    d.g[grp_idx].icrit = icrit_next;
                    if (issue_starts) begin
                        for (int j = 0; j < NUM_GROUPS; j++) begin
                            if (tgt.osucc[j]) begin
                                d.g[j].nexdone = q.g[j].nexdone + PRED_W'(1);
                            end
                            if (tgt.dsucc[j]) begin
                                d.g[j].nexing = q.g[j].nexing + PRED_W'(1);
                                d.g[j].crit   = f_max(d.g[j].crit, icrit_next);
                            end
                        end
                    end
                end
                mdg_pkg::OP_EXEC: begin
                    d.g[grp_idx].nfly  = tgt.nfly - INST_W'(1);
                    d.g[grp_idx].ndone = tgt.ndone + INST_W'(1);
                    if (exec_finishes) begin
                        for (int j = 0; j < NUM_GROUPS; j++) begin
                            if (tgt.dsucc[j]) begin
                                d.g[j].nexing  = q.g[j].nexing - PRED_W'(1);
                                d.g[j].nexdone = q.g[j].nexdone + PRED_W'(1);
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign crit_cycles_o = q.g[sel_idx].crit;
    assign err_o         = q.err;

endmodule

// File: rtl/mdg_checker.sv
module mdg_checker #(
    parameter int NUM_GROUPS = 16,
    parameter int IDX_W      = 4,
    parameter int CYC_W      = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid_i,
    input logic [IDX_W-1:0]      crit_sel_i,
    input logic [CYC_W-1:0]      crit_cycles_o,
    input logic [NUM_GROUPS-1:0] waiting_o,
    input logic [NUM_GROUPS-1:0] pending_o,
    input logic [NUM_GROUPS-1:0] ready_o,
    input logic [NUM_GROUPS-1:0] executing_o,
    input logic [NUM_GROUPS-1:0] executed_o,
    input logic                  err_o
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    always @(posedge clk) begin
        if (rst_n && !past_ok) begin
            reset_state_chk: assert (ready_o == '1 && executed_o == '1 && waiting_o == '0 &&
                                     pending_o == '0 && executing_o == '0 && !err_o &&
                                     crit_cycles_o == '0);
        end
    end

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R8
    reject_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(err_o)) |->
            $stable({waiting_o, pending_o, ready_o, executing_o, executed_o}));

    // R7
    tick_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(cmd_valid_i)) |->
            $stable({waiting_o, pending_o, ready_o, executing_o, executed_o}));

    // R7
    crit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(cmd_valid_i) && $stable(crit_sel_i)) |->
            (crit_cycles_o <= $past(crit_cycles_o)) &&
            ({1'b0, crit_cycles_o} + 1'b1 >= {1'b0, $past(crit_cycles_o)}));

    // R2
    readiness_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((waiting_o | pending_o | ready_o) == '1) &&
                    ((waiting_o & pending_o) == '0) && ((waiting_o & ready_o) == '0) &&
                    ((pending_o & ready_o) == '0));

endmodule

bind mdg_tracker mdg_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .IDX_W      ($clog2(NUM_GROUPS)),
    .CYC_W      (CYC_W)
) u_mdg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid_i   (cmd_valid_i),
    .crit_sel_i    (crit_sel_i),
    .crit_cycles_o (crit_cycles_o),
    .waiting_o     (waiting_o),
    .pending_o     (pending_o),
    .ready_o       (ready_o),
    .executing_o   (executing_o),
    .executed_o    (executed_o),
    .err_o         (err_o)
);

// File: tb/tb_mdg_tracker.sv
`timescale 1ns/1ps
module tb_mdg_tracker;

    localparam int N  = 16;
    localparam int IW = 4;
    localparam int CW = 8;
    localparam int XW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid_i = 1'b0;
    logic [1:0]    cmd_op_i = '0;
    logic [XW-1:0] cmd_grp_i = '0;
    logic [XW-1:0] cmd_succ_i = '0;
    logic          cmd_data_i = 1'b0;
    logic [CW-1:0] cmd_cycles_i = '0;
    logic          tick_i = 1'b0;
    logic [XW-1:0] crit_sel_i = '0;
    logic [CW-1:0] crit_cycles_o;
    logic [N-1:0]  waiting_o, pending_o, ready_o, executing_o, executed_o;
    logic          err_o;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state
    int m_npred [N];
    int m_nexing [N];
    int m_nexdone [N];
    int m_ninst [N];
    int m_nfly [N];
    int m_ndone [N];
    int m_crit [N];
    int m_icrit [N];
    bit [N-1:0] m_os [N];
    bit [N-1:0] m_ds [N];
    bit m_err;

    mdg_tracker #(.NUM_GROUPS(N), .INST_W(IW), .CYC_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_grp_i(cmd_grp_i), .cmd_succ_i(cmd_succ_i), .cmd_data_i(cmd_data_i),
        .cmd_cycles_i(cmd_cycles_i), .tick_i(tick_i), .crit_sel_i(crit_sel_i),
        .crit_cycles_o(crit_cycles_o), .waiting_o(waiting_o), .pending_o(pending_o),
        .ready_o(ready_o), .executing_o(executing_o), .executed_o(executed_o), .err_o(err_o)
    );

    always #5 clk = ~clk;

    function automatic bit f_wait(int i);  return m_npred[i] > m_nexing[i] + m_nexdone[i]; endfunction
    function automatic bit f_pend(int i);  return m_nexing[i] > 0 && m_nexing[i] + m_nexdone[i] == m_npred[i]; endfunction
    function automatic bit f_ready(int i); return m_nexdone[i] == m_npred[i]; endfunction
    function automatic bit f_exing(int i); return m_nfly[i] > 0 && m_nfly[i] == m_ninst[i] - m_ndone[i]; endfunction
    function automatic bit f_exed(int i);  return m_ninst[i] == m_ndone[i]; endfunction
    function automatic int f_max(int a, int b); return (a > b) ? a : b; endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_npred[i] = 0; m_nexing[i] = 0; m_nexdone[i] = 0;
            m_ninst[i] = 0; m_nfly[i] = 0; m_ndone[i] = 0;
            m_crit[i] = 0; m_icrit[i] = 0; m_os[i] = '0; m_ds[i] = '0;
        end
        m_err = 1'b0;
    endtask

    task automatic model_step(bit v, int op, int g, int s, bit dk, int c, bit tk);
        bit wt [N];
        bit ok;
        bit ex;
        for (int i = 0; i < N; i++) wt[i] = f_wait(i);
        if (tk) for (int i = 0; i < N; i++) if (wt[i] && m_crit[i] > 0) m_crit[i]--;
        if (!v) return;
        case (op)
            0: ok = ((m_os[g] | m_ds[g]) == '0) && m_ninst[g] < 15;
            1: ok = (s != g) && !f_exed(g) && !m_os[g][s] && !m_ds[g][s];
            2: ok = m_nfly[g] + m_ndone[g] < m_ninst[g];
            default: ok = f_ready(g) && m_nfly[g] > 0;
        endcase
        if (!ok) begin m_err = 1'b1; return; end
        case (op)
            0: m_ninst[g]++;
            1: begin
                ex = f_exing(g);
                if (dk || !ex) begin
                    m_npred[s]++;
                    if (ex) begin m_nexing[s]++; m_crit[s] = f_max(m_crit[s], m_icrit[g]); end
                    if (dk) m_ds[g][s] = 1'b1; else m_os[g][s] = 1'b1;
                end
            end
            2: begin
                m_nfly[g]++;
                m_icrit[g] = f_max(m_icrit[g], c);
                if (m_nfly[g] + m_ndone[g] == m_ninst[g]) begin
                    for (int j = 0; j < N; j++) begin
                        if (m_os[g][j]) m_nexdone[j]++;
                        if (m_ds[g][j]) begin m_nexing[j]++; m_crit[j] = f_max(m_crit[j], m_icrit[g]); end
                    end
                end
            end
            default: begin
                m_nfly[g]--; m_ndone[g]++;
                if (m_ndone[g] == m_ninst[g])
                    for (int j = 0; j < N; j++) if (m_ds[g][j]) begin m_nexing[j]--; m_nexdone[j]++; end
            end
        endcase
    endtask

    task automatic compare_all();
        logic [N-1:0] ew, ep, er, ex, ed;
        for (int i = 0; i < N; i++) begin
            ew[i] = f_wait(i); ep[i] = f_pend(i); er[i] = f_ready(i);
            ex[i] = f_exing(i); ed[i] = f_exed(i);
        end
        chk("R2", "readiness flags", int'({waiting_o, pending_o, ready_o}) , int'({ew, ep, er}));
        chk("R3", "progress flags", int'({executing_o, executed_o}), int'({ex, ed}));
        chk("R8", "err", int'(err_o), int'(m_err));
        chk("R7", "critical cycles", int'(crit_cycles_o), m_crit[crit_sel_i]);
    endtask

    // Called at a falling edge; the result is compared at the next falling edge.
    task automatic cyc(bit v, int op, int g, int s, bit dk, int c, bit tk);
        cmd_valid_i = v; cmd_op_i = op[1:0]; cmd_grp_i = g[XW-1:0];
        cmd_succ_i = s[XW-1:0]; cmd_data_i = dk; cmd_cycles_i = c[CW-1:0]; tick_i = tk;
        model_step(v, op, g, s, dk, c, tk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_valid_i = 1'b0; tick_i = 1'b0;
        model_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        do_reset();
        // R1 reset state
        chk("R1", "ready after reset", int'(ready_o), 16'hffff);
        chk("R1", "executed after reset", int'(executed_o), 16'hffff);
        chk("R1", "other flags after reset", int'({waiting_o, pending_o, executing_o}), 0);
        chk("R1", "err/crit after reset", int'({err_o, crit_cycles_o}), 0);

        // R9 command without strobe does nothing
        cyc(0, 0, 7, 0, 0, 0, 0);
        chk("R9", "unstrobed add-inst", int'(executed_o[7]), 1);
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R9", "op 0 adds instruction", int'(executed_o[0]), 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0, 0);
        cyc(1, 0, 2, 0, 0, 0, 0);
        cyc(1, 1, 0, 1, 0, 0, 0);
        chk("R6", "order link makes successor wait", int'(waiting_o[1]), 1);
        crit_sel_i = 2;
        cyc(1, 1, 0, 2, 1, 0, 0);
        cyc(1, 2, 0, 0, 0, 5, 0);
        chk("R3", "partial issue not executing", int'(executing_o[0]), 0);
        chk("R4", "order succ still waiting", int'(waiting_o[1]), 1);
        cyc(1, 2, 0, 0, 0, 9, 0);
        chk("R4", "order succ released on start", int'(ready_o[1]), 1);
        chk("R4", "data succ pending on start", int'(pending_o[2]), 1);
        chk("R7", "crit raised to 9", int'(crit_cycles_o), 9);
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R7", "pending group no countdown", int'(crit_cycles_o), 9);
        cyc(1, 3, 0, 0, 0, 0, 0);
        chk("R5", "data succ held until all done", int'(pending_o[2]), 1);
        cyc(1, 3, 0, 0, 0, 0, 0);
        chk("R5", "data succ ready after last", int'({pending_o[2], ready_o[2], executed_o[0]}), 3'b011);

        cyc(1, 0, 3, 0, 0, 0, 0);
        cyc(1, 0, 4, 0, 0, 0, 0);
        cyc(1, 0, 5, 0, 0, 0, 0);
        cyc(1, 2, 3, 0, 0, 7, 0);
        cyc(1, 1, 3, 4, 0, 0, 0);
        chk("R6", "order link to executing is no-op", int'({ready_o[4], waiting_o[4]}), 2'b10);
        crit_sel_i = 5;
        cyc(1, 1, 3, 5, 1, 0, 0);
        chk("R6", "data link to executing pending", int'(pending_o[5]), 1);
        chk("R6", "data link inherits crit", int'(crit_cycles_o), 7);
        cyc(1, 0, 6, 0, 0, 0, 0);
        cyc(1, 1, 6, 5, 1, 0, 0);
        chk("R2", "second pred waiting", int'(waiting_o[5]), 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R7", "two ticks count down", int'(crit_cycles_o), 5);
        cyc(1, 2, 6, 0, 0, 3, 1);
        chk("R7", "tick then max same cycle", int'(crit_cycles_o), 4);
        chk("R4", "data succ pending", int'(pending_o[5]), 1);
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R8", "add-inst with successors rejected", int'({err_o, executed_o[0]}), 2'b11);
        cyc(1, 0, 7, 0, 0, 0, 0);
        chk("R8", "err sticky after good cmd", int'({err_o, executed_o[7]}), 2'b10);

        do_reset();
        cyc(1, 3, 0, 0, 0, 0, 0);
        chk("R8", "complete with nothing in flight", int'({err_o, executed_o[0]}), 2'b11);
        do_reset();
        cyc(1, 2, 4, 0, 0, 3, 0);
        chk("R8", "issue on empty group", int'({err_o, executing_o[4]}), 2'b10);
        do_reset();
        cyc(1, 0, 1, 0, 0, 0, 0);
        cyc(1, 1, 1, 1, 0, 0, 0);
        chk("R8", "self link rejected", int'({err_o, waiting_o[1]}), 2'b10);

        for (int ep = 0; ep < 20; ep++) begin
            do_reset();
            for (int k = 0; k < 200; k++) begin
                crit_sel_i = XW'($urandom % 6);
                cyc(($urandom % 8) != 0, int'($urandom % 4), int'($urandom % 6),
                    int'($urandom % 6), bit'($urandom % 2), int'($urandom % 32), bit'($urandom % 2));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule